// File: doc/BRIEF.md
# Private-Cache Line Coherence Controller

This block is the coherence engine for the lines of a private first-level cache in a directory-based MESI system. It keeps a small fully-associative table. Each entry holds a line tag, a coherence state, a dirty flag and a signed pending-acknowledge count.

The block handles at most one event per cycle, taken from three sources:

- processor events, already classified as load, fetch, store or replacement;
- forwarded requests from the shared second-level bank;
- classified responses.

For each event it decides the next state of the line. It issues requests, data or acknowledge replies, and unblock messages toward the bank. It also raises read and write completion strobes toward the processor.

Transient states cover outstanding reads, writes, upgrades and writebacks. A processor event that hits a transient line is handed back for retry rather than consumed. Data storage, message transport and the bank's own behaviour sit outside the block.

A lookup port reports the state and access permission of any tag, so the surrounding cache can gate its data array.

Top module: `l1_coh_ctrl`

## Requirements
- R1: After reset every line is absent. A lookup of any tag returns state code 0 (not present) and permission 0 (invalid), and no output strobe fires. State codes are: 0 absent, 1 I, 2 S, 3 E, 4 M, 5 read-pending, 6 write-pending, 7 upgrade-pending, 8 read-pending-invalidated, 9 evicting, 10 reserved.
- R2: Only one event is handled per cycle, with responses first, then forwarded requests, then processor events. An event that loses arbitration is not taken (its take strobe is low) and has no effect.
- R3: A processor event (cpu_op 0 load, 1 fetch, 2 store, 3 replace) whose line is in a transient state (code 5 to 10) is recycled. cpu_retry is high, cpu_take is low, no message is issued and the state is unchanged.
- R4: A miss in absent or I allocates the line with a zero pending count. A load issues req_op 0 and a fetch issues req_op 1, both entering code 5; a store issues req_op 2 and enters code 6. A miss on an absent line while all entries are in use is recycled. All outputs are registered and appear one cycle after the event is taken.
- R5: A load or fetch in S, E or M raises rd_done. A store in S issues req_op 3 and enters code 7. A store in E or M raises wr_done, marks the line dirty and leaves it in M.
- R6: An invalidate (fwd_op 0) in absent, I, S or E returns an acknowledge (fo_data 0) to the requestor. S and E end in I; absent stays absent. In M or evicting, it sends the data with its dirty flag to the bank instead and ends in I. In codes 5 or 8 it acknowledges and enters code 8. In codes 6 or 7 it acknowledges and enters code 6.
- R7: Replacement of I or S drops the line silently. Replacement of E or M issues req_op 4 carrying the dirty flag and enters code 9. A writeback acknowledge (rsp_op 3) in code 9 moves the line to I.
- R8: A forwarded exclusive request (fwd_op 1 or 2) in E, M or code 9 sends data with the dirty flag to the requestor and ends in I. A forwarded shared request (fwd_op 3 or 4) sends data to both the requestor and the bank. It ends in S from E or M, and in I from code 9.
- R9: Read data (rsp_op 0) in code 5 or 8 completes the load when it comes from a peer cache or its count leaves nothing pending. It ends in S (from 5) or I (from 8), raises rd_done and sends an unblock with unb_excl 0. Exclusive data (rsp_op 1) in code 5 or 8 enters E, raises rd_done and sends an unblock with unb_excl 1.
- R10: Acknowledge counts are two's complement and are subtracted from the pending count. Data in code 6 that leaves a nonzero count enters code 7. Data in code 6 leaving zero, or an acknowledge (rsp_op 2) in code 7 leaving zero, enters M, marks the line dirty, raises wr_done and sends an unblock with unb_excl 1. Any other acknowledge in code 6 or 7 only updates the count.
- R11: look_perm is 0 (invalid) for absent and I, 1 (read-only) for S and E, 2 (read-write) for M, and 3 (busy) for every transient state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor event present |
| cpu_op | input | 2 | Processor event class |
| cpu_tag | input | TAG_W | Processor event line tag |
| cpu_take | output | 1 | Processor event consumed this cycle |
| cpu_retry | output | 1 | Processor event recycled this cycle |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_op | input | 3 | Forwarded request class |
| fwd_tag | input | TAG_W | Forwarded request line tag |
| fwd_take | output | 1 | Forwarded request consumed this cycle |
| rsp_valid | input | 1 | Response present (always consumed) |
| rsp_op | input | 2 | Response class |
| rsp_tag | input | TAG_W | Response line tag |
| rsp_acks | input | ACK_W | Signed acknowledge count carried by the response |
| rsp_from_l1 | input | 1 | Response sent by a peer first-level cache |
| rsp_dirty | input | 1 | Dirty flag carried with response data |
| look_tag | input | TAG_W | Tag to look up |
| look_state | output | 4 | State code of the looked-up tag |
| look_perm | output | 2 | Access permission of the looked-up tag |
| req_valid | output | 1 | Request message strobe |
| req_op | output | 3 | Request class |
| req_tag | output | TAG_W | Request line tag |
| req_dirty | output | 1 | Dirty flag carried by a writeback request |
| fo_valid | output | 1 | Reply message strobe |
| fo_data | output | 1 | Reply carries data (0 = acknowledge) |
| fo_to_req | output | 1 | Reply addressed to the requestor |
| fo_to_l2 | output | 1 | Reply addressed to the bank |
| fo_dirty | output | 1 | Dirty flag of the reply data |
| fo_tag | output | TAG_W | Reply line tag |
| unb_valid | output | 1 | Unblock message strobe |
| unb_excl | output | 1 | Unblock is exclusive |
| unb_tag | output | TAG_W | Unblock line tag |
| rd_done | output | 1 | Read completion strobe |
| wr_done | output | 1 | Write completion strobe |
| done_tag | output | TAG_W | Completion line tag |

## Verification
The bench builds the block with its defaults: 8-bit tags, four table entries and 4-bit acknowledge counts. With four entries, a table-full miss is reached after only a handful of fills, and freeing one entry by replacement makes the same miss succeed. The 4-bit count lets negative counts from the bank wrap and cancel against later single acknowledges, in either arrival order. The bench also presents colliding sources in one cycle to expose the arbitration order.

// File: rtl/l1_coh_ctrl.sv
module l1_coh_ctrl #(
  parameter int TAG_W   = 8,
  parameter int ENTRIES = 4,
  parameter int ACK_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic [1:0]       cpu_op,
  input  logic [TAG_W-1:0] cpu_tag,
  output logic             cpu_take,
  output logic             cpu_retry,
  input  logic             fwd_valid,
  input  logic [2:0]       fwd_op,
  input  logic [TAG_W-1:0] fwd_tag,
  output logic             fwd_take,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_op,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic [ACK_W-1:0] rsp_acks,
  input  logic             rsp_from_l1,
  input  logic             rsp_dirty,
  input  logic [TAG_W-1:0] look_tag,
  output logic [3:0]       look_state,
  output logic [1:0]       look_perm,
  output logic             req_valid,
  output logic [2:0]       req_op,
  output logic [TAG_W-1:0] req_tag,
  output logic             req_dirty,
  output logic             fo_valid,
  output logic             fo_data,
  output logic             fo_to_req,
  output logic             fo_to_l2,
  output logic             fo_dirty,
  output logic [TAG_W-1:0] fo_tag,
  output logic             unb_valid,
  output logic             unb_excl,
  output logic [TAG_W-1:0] unb_tag,
  output logic             rd_done,
  output logic             wr_done,
  output logic [TAG_W-1:0] done_tag
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  localparam logic [3:0] S_NP = 4'd0, S_I = 4'd1, S_S = 4'd2, S_E = 4'd3, S_M = 4'd4;
  localparam logic [3:0] S_IS = 4'd5, S_IM = 4'd6, S_SM = 4'd7, S_ISI = 4'd8, S_MI = 4'd9, S_EI = 4'd10;

  localparam logic [1:0] C_LD = 2'd0, C_IF = 2'd1, C_ST = 2'd2;
  localparam logic [2:0] F_INV = 3'd0, F_GETX = 3'd1, F_UPG = 3'd2, F_GETS = 3'd3, F_GETI = 3'd4;
  localparam logic [1:0] R_DATA = 2'd0, R_DEX = 2'd1, R_ACK = 2'd2;
  localparam logic [2:0] Q_GETS = 3'd0, Q_GETI = 3'd1, Q_GETX = 3'd2, Q_UPG = 3'd3, Q_PUTX = 3'd4;

  logic [3:0]       st_q   [ENTRIES];
  logic [TAG_W-1:0] tag_q  [ENTRIES];
  logic [ACK_W-1:0] pend_q [ENTRIES];
  logic [ENTRIES-1:0] dirty_q;

  wire use_rsp = rsp_valid;
  wire use_fwd = fwd_valid & ~rsp_valid;
  wire use_cpu = cpu_valid & ~rsp_valid & ~fwd_valid;
  wire [TAG_W-1:0] ev_tag = use_rsp ? rsp_tag : (use_fwd ? fwd_tag : cpu_tag);

  logic [ENTRIES-1:0] hit_vec;
  logic [IW-1:0]      hidx, fidx;
  logic               free_any;

  always_comb begin
    hit_vec    = '0;
    hidx       = '0;
    fidx       = '0;
    free_any   = 1'b0;
    look_state = S_NP;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (st_q[i] != S_NP && tag_q[i] == ev_tag) begin
        hit_vec[i] = 1'b1;
        hidx       = IW'(i);
      end
      if (st_q[i] == S_NP) begin
        free_any = 1'b1;
        fidx     = IW'(i);
      end
      if (st_q[i] != S_NP && tag_q[i] == look_tag) look_state = st_q[i];
    end
  end

  always_comb begin
    case (look_state)
      S_S, S_E:                              look_perm = 2'd1;
      S_M:                                   look_perm = 2'd2;
      S_IS, S_IM, S_SM, S_ISI, S_MI, S_EI:   look_perm = 2'd3;
      default:                               look_perm = 2'd0;
    endcase
  end

  wire             hit_any   = |hit_vec;
  wire [3:0]       cur       = hit_any ? st_q[hidx] : S_NP;
  wire             cur_dirty = hit_any & dirty_q[hidx];
  wire [ACK_W-1:0] cur_pend  = hit_any ? pend_q[hidx] : '0;
  wire [ACK_W-1:0] pend_left = cur_pend - rsp_acks;
  wire             all_in    = (pend_left == '0);
  wire             busy      = (cur >= S_IS);

  logic [3:0]       n_st;
  logic             n_dirty, wr_en;
  logic [ACK_W-1:0] n_pend;
  logic [IW-1:0]    widx;
  logic             take_c, retry_c;
  logic             q_v, q_d;
  logic [2:0]       q_op;
  logic             f_v, f_data, f_req, f_l2, f_d;
  logic             u_v, u_x, d_rd, d_wr;

  always_comb begin
    n_st = cur; n_dirty = cur_dirty; n_pend = cur_pend; wr_en = 1'b0; widx = hidx;
    take_c = 1'b0; retry_c = 1'b0;
    q_v = 1'b0; q_op = Q_GETS; q_d = 1'b0;
    f_v = 1'b0; f_data = 1'b0; f_req = 1'b0; f_l2 = 1'b0; f_d = 1'b0;
    u_v = 1'b0; u_x = 1'b0; d_rd = 1'b0; d_wr = 1'b0;
    if (use_rsp) begin
      case (rsp_op)
        R_DATA: begin
          if ((cur == S_IS || cur == S_ISI) && (rsp_from_l1 || all_in)) begin
            n_st = (cur == S_IS) ? S_S : S_I;
            n_dirty = rsp_dirty; wr_en = 1'b1; u_v = 1'b1; d_rd = 1'b1;
          end else if (cur == S_IM) begin
            wr_en = 1'b1;
            if (all_in) begin
              n_st = S_M; n_dirty = 1'b1; u_v = 1'b1; u_x = 1'b1; d_wr = 1'b1;
            end else begin
              n_st = S_SM; n_pend = pend_left; n_dirty = rsp_dirty;
            end
          end
        end
        R_DEX: begin
          if (cur == S_IS || cur == S_ISI) begin
            n_st = S_E; n_dirty = rsp_dirty; wr_en = 1'b1;
            u_v = 1'b1; u_x = 1'b1; d_rd = 1'b1;
          end
        end
        R_ACK: begin
          if (cur == S_SM && all_in) begin
            n_st = S_M; n_dirty = 1'b1; n_pend = '0; wr_en = 1'b1;
            u_v = 1'b1; u_x = 1'b1; d_wr = 1'b1;
          end else if (cur == S_IM || cur == S_SM) begin
            n_pend = pend_left; wr_en = 1'b1;
          end
        end
        default: begin
          if (cur == S_MI) begin
            n_st = S_I; n_dirty = 1'b0; wr_en = 1'b1;
          end
        end
      endcase
    end else if (use_fwd) begin
      case (fwd_op)
        F_INV: begin
          case (cur)
            S_NP, S_I: begin f_v = 1'b1; f_req = 1'b1; end
            S_S, S_E: begin f_v = 1'b1; f_req = 1'b1; n_st = S_I; n_dirty = 1'b0; wr_en = 1'b1; end
            S_M, S_MI: begin
              f_v = 1'b1; f_data = 1'b1; f_l2 = 1'b1; f_d = cur_dirty;
              n_st = S_I; n_dirty = 1'b0; wr_en = 1'b1;
            end
            S_IS, S_ISI: begin f_v = 1'b1; f_req = 1'b1; n_st = S_ISI; wr_en = 1'b1; end
            S_IM, S_SM: begin f_v = 1'b1; f_req = 1'b1; n_st = S_IM; wr_en = 1'b1; end
            default: ;
          endcase
        end
        F_GETX, F_UPG: begin
          if (cur == S_E || cur == S_M || cur == S_MI) begin
            f_v = 1'b1; f_data = 1'b1; f_req = 1'b1; f_d = cur_dirty;
            n_st = S_I; n_dirty = 1'b0; wr_en = 1'b1;
          end
        end
        F_GETS, F_GETI: begin
          if (cur == S_E || cur == S_M || cur == S_MI) begin
            f_v = 1'b1; f_data = 1'b1; f_req = 1'b1; f_l2 = 1'b1; f_d = cur_dirty;
            n_st = (cur == S_MI) ? S_I : S_S; n_dirty = 1'b0; wr_en = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (use_cpu) begin
      if (busy) begin
        retry_c = 1'b1;
      end else if (cpu_op == C_LD || cpu_op == C_IF || cpu_op == C_ST) begin
        if (cpu_op != C_ST && (cur == S_S || cur == S_E || cur == S_M)) begin
          take_c = 1'b1; d_rd = 1'b1;
        end else if (cpu_op == C_ST && cur == S_S) begin
          take_c = 1'b1; q_v = 1'b1; q_op = Q_UPG;
          n_st = S_SM; n_pend = '0; wr_en = 1'b1;
        end else if (cpu_op == C_ST && (cur == S_E || cur == S_M)) begin
          take_c = 1'b1; d_wr = 1'b1; n_st = S_M; n_dirty = 1'b1; wr_en = 1'b1;
        end else if (hit_any || free_any) begin
          take_c = 1'b1; q_v = 1'b1;
          q_op = (cpu_op == C_LD) ? Q_GETS : ((cpu_op == C_IF) ? Q_GETI : Q_GETX);
          n_st = (cpu_op == C_ST) ? S_IM : S_IS;
          n_pend = '0; n_dirty = 1'b0; wr_en = 1'b1;
          widx = hit_any ? hidx : fidx;
        end else begin
          retry_c = 1'b1;
        end
      end else begin
        take_c = 1'b1;
        if (cur == S_I || cur == S_S) begin
          n_st = S_NP; n_dirty = 1'b0; wr_en = 1'b1;
        end else if (cur == S_E || cur == S_M) begin
          q_v = 1'b1; q_op = Q_PUTX; q_d = cur_dirty;
          n_st = S_MI; wr_en = 1'b1;
        end
      end
    end
  end

  assign cpu_take  = take_c;
  assign cpu_retry = retry_c;
  assign fwd_take  = use_fwd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st_q[i]   <= S_NP;
        tag_q[i]  <= '0;
        pend_q[i] <= '0;
      end
      dirty_q <= '0;
    end else if (wr_en) begin
      st_q[widx]    <= n_st;
      tag_q[widx]   <= ev_tag;
      pend_q[widx]  <= n_pend;
      dirty_q[widx] <= n_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0; req_op <= '0; req_tag <= '0; req_dirty <= 1'b0;
      fo_valid <= 1'b0; fo_data <= 1'b0; fo_to_req <= 1'b0; fo_to_l2 <= 1'b0;
      fo_dirty <= 1'b0; fo_tag <= '0;
      unb_valid <= 1'b0; unb_excl <= 1'b0; unb_tag <= '0;
      rd_done <= 1'b0; wr_done <= 1'b0; done_tag <= '0;
    end else begin
      req_valid <= q_v; req_op <= q_op; req_tag <= ev_tag; req_dirty <= q_d;
      fo_valid <= f_v; fo_data <= f_data; fo_to_req <= f_req; fo_to_l2 <= f_l2;
      fo_dirty <= f_d; fo_tag <= ev_tag;
      unb_valid <= u_v; unb_excl <= u_x; unb_tag <= ev_tag;
      rd_done <= d_rd; wr_done <= d_wr; done_tag <= ev_tag;
    end
  end

  // R1
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  // R2
  rsp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!cpu_take && !fwd_take));
  // R3
  recycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_retry |=> (!req_valid && !rd_done && !wr_done));
  // R6
  ack_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_valid && !fo_data) |-> (!fo_dirty && fo_to_req && !fo_to_l2));
  // R9
  unblock_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unb_valid |-> (rd_done || wr_done));
endmodule

// File: tb/l1_coh_ctrl_bench.sv
module l1_coh_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cpu_valid = 0; logic [1:0] cpu_op = 0; logic [7:0] cpu_tag = 0;
  logic fwd_valid = 0; logic [2:0] fwd_op = 0; logic [7:0] fwd_tag = 0;
  logic rsp_valid = 0; logic [1:0] rsp_op = 0; logic [7:0] rsp_tag = 0;
  logic [3:0] rsp_acks = 0; logic rsp_from_l1 = 0; logic rsp_dirty = 0;
  logic [7:0] look_tag = 0;
  logic cpu_take, cpu_retry, fwd_take;
  logic [3:0] look_state; logic [1:0] look_perm;
  logic req_valid, req_dirty; logic [2:0] req_op; logic [7:0] req_tag;
  logic fo_valid, fo_data, fo_to_req, fo_to_l2, fo_dirty; logic [7:0] fo_tag;
  logic unb_valid, unb_excl; logic [7:0] unb_tag;
  logic rd_done, wr_done; logic [7:0] done_tag;

  l1_coh_ctrl u_l1_coh_ctrl (
    .clk, .rst_n, .cpu_valid, .cpu_op, .cpu_tag, .cpu_take, .cpu_retry,
    .fwd_valid, .fwd_op, .fwd_tag, .fwd_take,
    .rsp_valid, .rsp_op, .rsp_tag, .rsp_acks, .rsp_from_l1, .rsp_dirty,
    .look_tag, .look_state, .look_perm,
    .req_valid, .req_op, .req_tag, .req_dirty,
    .fo_valid, .fo_data, .fo_to_req, .fo_to_l2, .fo_dirty, .fo_tag,
    .unb_valid, .unb_excl, .unb_tag, .rd_done, .wr_done, .done_tag);

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string rq_q[$];

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(logic [1:0] ch, logic [7:0] misc, logic [7:0] tag);
    return {ch, 14'h0, misc, tag};
  endfunction

  task automatic expect_out(logic [1:0] ch, logic [7:0] misc, logic [7:0] tag, string r);
    exp_q.push_back(pack(ch, misc, tag));
    rq_q.push_back(r);
  endtask

  task automatic got(logic [31:0] act);
    logic [31:0] e;
    string r;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3 unexpected output", act, 32'h0);
    end else begin
      e = exp_q.pop_front();
      r = rq_q.pop_front();
      chk(act == e, r, act, e);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (req_valid) got(pack(2'd0, {4'b0, req_op, req_dirty}, req_tag));
      if (fo_valid) got(pack(2'd1, {4'b0, fo_data, fo_to_req, fo_to_l2, fo_dirty}, fo_tag));
      if (unb_valid) got(pack(2'd2, {7'b0, unb_excl}, unb_tag));
      if (rd_done || wr_done) got(pack(2'd3, {6'b0, rd_done, wr_done}, done_tag));
    end
  end

  task automatic cpu_ev(logic [1:0] op, logic [7:0] tag, bit e_take, bit e_retry, string r);
    cpu_valid = 1; cpu_op = op; cpu_tag = tag;
    #1;
    chk(cpu_take == e_take && cpu_retry == e_retry, r, {cpu_take, cpu_retry}, {e_take, e_retry});
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic fwd_ev(logic [2:0] op, logic [7:0] tag);
    fwd_valid = 1; fwd_op = op; fwd_tag = tag;
    @(negedge clk);
    fwd_valid = 0;
  endtask

  task automatic rsp_ev(logic [1:0] op, logic [7:0] tag, logic [3:0] acks, bit l1, bit d);
    rsp_valid = 1; rsp_op = op; rsp_tag = tag; rsp_acks = acks; rsp_from_l1 = l1; rsp_dirty = d;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic look(logic [7:0] tag, logic [3:0] st, logic [1:0] perm, string r);
    look_tag = tag;
    #1;
    chk(look_state == st && look_perm == perm, r, {look_state, look_perm}, {st, perm});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    look(8'h10, 4'd0, 2'd0, "R1 reset lookup");
    repeat (2) @(negedge clk);

    // R4 load miss
    expect_out(0, {4'b0, 3'd0, 1'b0}, 8'h10, "R4 load issues GETS");
    cpu_ev(2'd0, 8'h10, 1, 0, "R4 load taken");
    look(8'h10, 4'd5, 2'd3, "R11 read-pending busy");
    // R3 recycle
    cpu_ev(2'd0, 8'h10, 0, 1, "R3 recycle in read-pending");
    look(8'h10, 4'd5, 2'd3, "R3 state unchanged");
    // R9 shared fill
    expect_out(2, 8'h00, 8'h10, "R9 shared unblock");
    expect_out(3, 8'h02, 8'h10, "R9 read done");
    rsp_ev(2'd0, 8'h10, 4'h0, 0, 0);
    look(8'h10, 4'd2, 2'd1, "R11 S read-only");
    // R5 load hit
    expect_out(3, 8'h02, 8'h10, "R5 load hit");
    cpu_ev(2'd0, 8'h10, 1, 0, "R5 hit taken");
    // R5 upgrade then R10 ack counting
    expect_out(0, {4'b0, 3'd3, 1'b0}, 8'h10, "R5 store in S upgrades");
    cpu_ev(2'd2, 8'h10, 1, 0, "R5 upgrade taken");
    look(8'h10, 4'd7, 2'd3, "R5 upgrade-pending");
    rsp_ev(2'd2, 8'h10, 4'h1, 0, 0);
    look(8'h10, 4'd7, 2'd3, "R10 early ack keeps state");
    expect_out(2, 8'h01, 8'h10, "R10 exclusive unblock");
    expect_out(3, 8'h01, 8'h10, "R10 write done");
    rsp_ev(2'd2, 8'h10, 4'hF, 0, 0);
    look(8'h10, 4'd4, 2'd2, "R11 M read-write");
    // R8 forwarded shared in M
    expect_out(1, 8'h0F, 8'h10, "R8 GETS data to both");
    fwd_ev(3'd3, 8'h10);
    look(8'h10, 4'd2, 2'd1, "R8 M to S");

    // R4 store miss, R6 inv in write-pending, R10 counts
    expect_out(0, {4'b0, 3'd2, 1'b0}, 8'h20, "R4 store issues GETX");
    cpu_ev(2'd2, 8'h20, 1, 0, "R4 store taken");
    expect_out(1, 8'h04, 8'h20, "R6 ack in write-pending");
    fwd_ev(3'd0, 8'h20);
    look(8'h20, 4'd6, 2'd3, "R6 stays write-pending");
    rsp_ev(2'd0, 8'h20, 4'hE, 0, 0);
    look(8'h20, 4'd7, 2'd3, "R10 data with pending acks");
    rsp_ev(2'd2, 8'h20, 4'h1, 0, 0);
    look(8'h20, 4'd7, 2'd3, "R10 one ack left");
    expect_out(2, 8'h01, 8'h20, "R10 exclusive unblock");
    expect_out(3, 8'h01, 8'h20, "R10 write done");
    rsp_ev(2'd2, 8'h20, 4'h1, 0, 0);
    look(8'h20, 4'd4, 2'd2, "R10 reaches M");
    // R7 M eviction, R8 GETX in evicting
    expect_out(0, {4'b0, 3'd4, 1'b1}, 8'h20, "R7 PUTX dirty");
    cpu_ev(2'd3, 8'h20, 1, 0, "R7 replace taken");
    cpu_ev(2'd0, 8'h20, 0, 1, "R3 recycle in evicting");
    look(8'h20, 4'd9, 2'd3, "R7 evicting busy");
    expect_out(1, 8'h0D, 8'h20, "R8 GETX from evicting copy");
    fwd_ev(3'd1, 8'h20);
    look(8'h20, 4'd1, 2'd0, "R11 I invalid");

    // R6/R9 invalidate overtakes read data
    expect_out(0, {4'b0, 3'd0, 1'b0}, 8'h30, "R4 load GETS");
    cpu_ev(2'd0, 8'h30, 1, 0, "R4 load taken");
    expect_out(1, 8'h04, 8'h30, "R6 ack in read-pending");
    fwd_ev(3'd0, 8'h30);
    look(8'h30, 4'd8, 2'd3, "R6 read-pending-invalidated");
    expect_out(2, 8'h00, 8'h30, "R9 unblock after overtaken read");
    expect_out(3, 8'h02, 8'h30, "R9 read done");
    rsp_ev(2'd0, 8'h30, 4'h0, 0, 0);
    look(8'h30, 4'd1, 2'd0, "R9 line left in I");

    // R9 exclusive fill, R5 store in E, R6 inv in M
    expect_out(0, {4'b0, 3'd0, 1'b0}, 8'h40, "R4 load GETS");
    cpu_ev(2'd0, 8'h40, 1, 0, "R4 load taken");
    expect_out(2, 8'h01, 8'h40, "R9 exclusive unblock");
    expect_out(3, 8'h02, 8'h40, "R9 read done");
    rsp_ev(2'd1, 8'h40, 4'h0, 0, 0);
    look(8'h40, 4'd3, 2'd1, "R11 E read-only");
    expect_out(3, 8'h01, 8'h40, "R5 store in E");
    cpu_ev(2'd2, 8'h40, 1, 0, "R5 store taken");
    look(8'h40, 4'd4, 2'd2, "R5 E to M");
    expect_out(1, 8'h0B, 8'h40, "R6 inv in M sends data to bank");
    fwd_ev(3'd0, 8'h40);
    look(8'h40, 4'd1, 2'd0, "R6 M to I");

    // R4 table full
    cpu_ev(2'd0, 8'h50, 0, 1, "R4 full table recycles");
    cpu_ev(2'd3, 8'h20, 1, 0, "R7 replace of I taken");
    look(8'h20, 4'd0, 2'd0, "R7 I dropped silently");
    expect_out(0, {4'b0, 3'd0, 1'b0}, 8'h50, "R4 load after free");
    cpu_ev(2'd0, 8'h50, 1, 0, "R4 load taken");

    // R2 priority
    rsp_valid = 1; rsp_op = 2'd1; rsp_tag = 8'h50; rsp_acks = 0; rsp_from_l1 = 0; rsp_dirty = 0;
    fwd_valid = 1; fwd_op = 3'd0; fwd_tag = 8'h10;
    cpu_valid = 1; cpu_op = 2'd0; cpu_tag = 8'h10;
    #1;
    chk(!cpu_take && !cpu_retry && !fwd_take, "R2 response wins", {cpu_take, cpu_retry, fwd_take}, 3'b000);
    expect_out(2, 8'h01, 8'h50, "R2 response handled");
    expect_out(3, 8'h02, 8'h50, "R2 response done");
    @(negedge clk);
    rsp_valid = 0; cpu_op = 2'd2;
    #1;
    chk(fwd_take && !cpu_take, "R2 forward beats processor", {fwd_take, cpu_take}, 2'b10);
    expect_out(1, 8'h04, 8'h10, "R2 forward handled");
    @(negedge clk);
    fwd_valid = 0; cpu_valid = 0;
    look(8'h10, 4'd1, 2'd0, "R2 store not taken, inv applied");

    // R7 E eviction and writeback ack
    expect_out(0, {4'b0, 3'd4, 1'b0}, 8'h50, "R7 PUTX clean");
    cpu_ev(2'd3, 8'h50, 1, 0, "R7 E replace");
    rsp_ev(2'd3, 8'h50, 4'h0, 0, 0);
    look(8'h50, 4'd1, 2'd0, "R7 writeback ack to I");

    // R4 fetch, R9 data from peer
    expect_out(0, {4'b0, 3'd1, 1'b0}, 8'h10, "R4 fetch GET_INSTR");
    cpu_ev(2'd1, 8'h10, 1, 0, "R4 fetch taken");
    expect_out(2, 8'h00, 8'h10, "R9 peer data unblock");
    expect_out(3, 8'h02, 8'h10, "R9 peer data done");
    rsp_ev(2'd0, 8'h10, 4'h3, 1, 0);
    look(8'h10, 4'd2, 2'd1, "R9 peer fill to S");
    expect_out(1, 8'h04, 8'h77, "R6 inv on absent line acked");
    fwd_ev(3'd0, 8'h77);

    // R6 inv while evicting
    expect_out(0, {4'b0, 3'd2, 1'b0}, 8'h30, "R4 GETX from I");
    cpu_ev(2'd2, 8'h30, 1, 0, "R4 store taken");
    expect_out(2, 8'h01, 8'h30, "R10 all-acks data unblock");
    expect_out(3, 8'h01, 8'h30, "R10 write done");
    rsp_ev(2'd0, 8'h30, 4'h0, 0, 0);
    expect_out(0, {4'b0, 3'd4, 1'b1}, 8'h30, "R7 PUTX dirty");
    cpu_ev(2'd3, 8'h30, 1, 0, "R7 replace");
    expect_out(1, 8'h0B, 8'h30, "R6 inv in evicting sends copy");
    fwd_ev(3'd0, 8'h30);
    look(8'h30, 4'd1, 2'd0, "R6 evicting to I");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected outputs seen", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule